// File: doc/BRIEF.md
# Coprocessor Register Window with Paged Microcode

This block is the word-addressed slave side of a microcoded vertex coprocessor. A host issues single 32-bit accesses on a plain valid/write/address/data strobe. The block turns the byte address into a word index and routes the access to one of three places: a twelve-entry control and status file, a 128-entry general register file, or a 512-word view into a 2048-word microcode store.

Four times more microcode exists than the window can show at once. The page number held in the code-page register selects which quarter is visible. A write of bit 0 to the control word sends a one-cycle launch pulse to the sequencer. A read of that word returns the sequencer's busy state.

The sequencer has its own ports. It has a read port into the microcode store, and a read port and a write port into the general register file. The mesh base and the two mesh limits are driven out as configuration.

Top module: `vcop_regwin`

## Requirements
- R1: The word index is bus_addr shifted right by two. The two low address bits never change which word an access reaches.
- R2: Word indices 1 to 11 hold mesh base, horizontal last, vertical last, code page, vertex count, collisions, stray writes, last DMA address, program counter, data-register base and code base, in that order. Each reads back the full 32-bit value last written to it. cfg_mesh_base, cfg_hlast and cfg_vlast show indices 1, 2 and 3 and change only on a bus write.
- R3: A write to word index 0 with bit 0 set drives run_start high for exactly the next cycle. A write to index 0 with bit 0 clear gives no pulse. Control writes are not stored.
- R4: A read of word index 0 returns run_busy, as sampled in the request cycle, in bit 0 and zero in bits 31:1.
- R5: Word indices 0x100 to 0x17F reach general registers 0 to 127. seq_gpr_rdata gives the register at seq_gpr_raddr one cycle after the address.
- R6: Word indices 0x200 to 0x3FF reach microcode word 512*P + (index - 0x200). P is the two low bits of the code-page register, so page values above 3 wrap.
- R7: seq_uc_rdata gives microcode word seq_uc_addr one cycle after the address is presented.
- R8: When seq_gpr_we is high, seq_gpr_wdata is written to register seq_gpr_waddr. If the bus writes the same register in the same cycle, the sequencer value is kept.
- R9: Word indices 12 to 0xFF, 0x180 to 0x1FF and 0x400 upward are unmapped. A read of one returns zero and a write to one changes nothing. Either access raises bus_err for the single following cycle.
- R10: Reset clears every control register, every general register and the whole microcode store. After reset all reads return zero and run_start and bus_err are low.
- R11: bus_rdata takes the read result in the cycle after a read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Unmapped access flag, one cycle |
| run_start | output | 1 | Launch pulse to the sequencer |
| run_busy | input | 1 | Sequencer busy |
| cfg_mesh_base | output | 32 | Mesh base register |
| cfg_hlast | output | 32 | Horizontal last register |
| cfg_vlast | output | 32 | Vertical last register |
| seq_gpr_raddr | input | 7 | Sequencer general register read address |
| seq_gpr_rdata | output | 32 | Sequencer general register read data |
| seq_gpr_we | input | 1 | Sequencer general register write enable |
| seq_gpr_waddr | input | 7 | Sequencer general register write address |
| seq_gpr_wdata | input | 32 | Sequencer general register write data |
| seq_uc_addr | input | 11 | Sequencer microcode read address |
| seq_uc_rdata | output | 32 | Sequencer microcode read data |

## Verification
The assertions assume that run_busy and the bus strobes change only between clock edges. They also assume that a cycle with bus_valid low carries no access, whatever bus_write and bus_addr hold. The bench drives every input on the falling edge and lowers bus_valid after each access, so each cycle holds at most one request. Random stimulus covers all three windows and the unmapped ranges. It also rewrites the code page at random, so microcode traffic crosses pages.

// File: rtl/vcop_pkg.sv
package vcop_pkg;
  typedef enum logic [2:0] {
    RG_CTL  = 3'd0,
    RG_CSR  = 3'd1,
    RG_GPR  = 3'd2,
    RG_UC   = 3'd3,
    RG_NONE = 3'd4
  } region_e;

  // control file slots whose position other logic depends on
  localparam int unsigned SLOT_MESH  = 1;
  localparam int unsigned SLOT_HLAST = 2;
  localparam int unsigned SLOT_VLAST = 3;
  localparam int unsigned SLOT_PAGE  = 4;
endpackage

// File: rtl/vcop_addr_dec.sv
module vcop_addr_dec
  import vcop_pkg::*;
#(
  parameter int unsigned WIDX_W    = 12,
  parameter int unsigned NUM_CSR   = 12,
  parameter int unsigned GPR_BASE  = 256,
  parameter int unsigned GPR_DEPTH = 128,
  parameter int unsigned UC_BASE   = 512,
  parameter int unsigned UC_WIN    = 512,
  parameter int unsigned CSR_AW    = 4,
  parameter int unsigned GPR_AW    = 7,
  parameter int unsigned WIN_AW    = 9
) (
  input  logic [WIDX_W-1:0] widx,
  output region_e           region,
  output logic [CSR_AW-1:0] csr_idx,
  output logic [GPR_AW-1:0] gpr_idx,
  output logic [WIN_AW-1:0] win_off
);
  logic [31:0] w32;

  always_comb begin
    w32     = 32'(widx);
    csr_idx = CSR_AW'(w32);
    gpr_idx = GPR_AW'(w32 - GPR_BASE);
    win_off = WIN_AW'(w32 - UC_BASE);
    if (w32 == 32'd0)
      region = RG_CTL;
    else if (w32 < NUM_CSR)
      region = RG_CSR;
    else if (w32 >= GPR_BASE && w32 < GPR_BASE + GPR_DEPTH)
      region = RG_GPR;
    else if (w32 >= UC_BASE && w32 < UC_BASE + UC_WIN)
      region = RG_UC;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/vcop_csr_file.sv
module vcop_csr_file
  import vcop_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_CSR = 12,
  parameter int unsigned CSR_AW  = 4,
  parameter int unsigned PAGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  output logic [DW-1:0]     rdata_q,
  output logic              start_q,
  output logic [DW-1:0]     mesh_base,
  output logic [DW-1:0]     hlast,
  output logic [DW-1:0]     vlast,
  output logic [PAGE_W-1:0] page
);
  logic [DW-1:0] regs [NUM_CSR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_CSR); i++) regs[i] <= '0;
      rdata_q <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= ctl_wr & wdata[0];
      if (csr_wr) regs[idx] <= wdata;
      if (ctl_rd)
        rdata_q <= DW'(busy);
      else if (csr_rd)
        rdata_q <= regs[idx];
    end
  end

  assign mesh_base = regs[SLOT_MESH];
  assign hlast     = regs[SLOT_HLAST];
  assign vlast     = regs[SLOT_VLAST];
  assign page      = regs[SLOT_PAGE][PAGE_W-1:0];
endmodule

// File: rtl/vcop_gpr_file.sv
module vcop_gpr_file #(
  parameter int unsigned DW     = 32,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned AW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata_q,
  input  logic [AW-1:0] seq_raddr,
  output logic [DW-1:0] seq_rdata_q,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_waddr,
  input  logic [DW-1:0] seq_wdata
);
  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) regs[i] <= '0;
      bus_rdata_q <= '0;
      seq_rdata_q <= '0;
    end else begin
      if (bus_we) regs[bus_addr] <= bus_wdata;
      // the sequencer port is assigned last so it wins a same-address clash
      if (seq_we) regs[seq_waddr] <= seq_wdata;
      if (bus_re) bus_rdata_q <= regs[bus_addr];
      seq_rdata_q <= regs[seq_raddr];
    end
  end
endmodule

// File: rtl/vcop_ucode_store.sv
module vcop_ucode_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    a_q, b_q;
  logic             a_vq, b_vq;

  // array without reset so it maps to a dual-port block RAM
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

  // per-word written flags stand in for clearing the array on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      a_vq <= 1'b0;
      b_vq <= 1'b0;
    end else begin
      if (a_we) vld[a_addr] <= 1'b1;
      if (a_re) a_vq <= vld[a_addr];
      b_vq <= vld[b_addr];
    end
  end

  assign a_rdata = a_q & {DW{a_vq}};
  assign b_rdata = b_q & {DW{b_vq}};
endmodule

// File: rtl/vcop_regwin.sv
module vcop_regwin
  import vcop_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned NUM_CSR   = 12,
  parameter int unsigned GPR_BASE  = 256,
  parameter int unsigned GPR_DEPTH = 128,
  parameter int unsigned UC_BASE   = 512,
  parameter int unsigned UC_WIN    = 512,
  parameter int unsigned UC_DEPTH  = 2048
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_err,
  output logic                         run_start,
  input  logic                         run_busy,
  output logic [31:0]                  cfg_mesh_base,
  output logic [31:0]                  cfg_hlast,
  output logic [31:0]                  cfg_vlast,
  input  logic [$clog2(GPR_DEPTH)-1:0] seq_gpr_raddr,
  output logic [31:0]                  seq_gpr_rdata,
  input  logic                         seq_gpr_we,
  input  logic [$clog2(GPR_DEPTH)-1:0] seq_gpr_waddr,
  input  logic [31:0]                  seq_gpr_wdata,
  input  logic [$clog2(UC_DEPTH)-1:0]  seq_uc_addr,
  output logic [31:0]                  seq_uc_rdata
);
  localparam int unsigned DW     = 32;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned CSR_AW = $clog2(NUM_CSR);
  localparam int unsigned GPR_AW = $clog2(GPR_DEPTH);
  localparam int unsigned UC_AW  = $clog2(UC_DEPTH);
  localparam int unsigned WIN_AW = $clog2(UC_WIN);
  localparam int unsigned PAGE_W = UC_AW - WIN_AW;

  logic [WIDX_W-1:0] widx;
  logic [1:0]        unused_byte_lane;
  region_e           region, region_q;
  logic [CSR_AW-1:0] csr_idx;
  logic [GPR_AW-1:0] gpr_idx;
  logic [WIN_AW-1:0] win_off;
  logic [PAGE_W-1:0] page;
  logic              rd_req, wr_req;
  logic [DW-1:0]     csr_rd, gpr_rd, uc_rd;
  logic              err_q;

  assign widx             = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr[1:0];
  assign rd_req           = bus_valid & ~bus_write;
  assign wr_req           = bus_valid & bus_write;

  vcop_addr_dec #(
    .WIDX_W(WIDX_W), .NUM_CSR(NUM_CSR), .GPR_BASE(GPR_BASE),
    .GPR_DEPTH(GPR_DEPTH), .UC_BASE(UC_BASE), .UC_WIN(UC_WIN),
    .CSR_AW(CSR_AW), .GPR_AW(GPR_AW), .WIN_AW(WIN_AW)
  ) u_dec (
    .widx(widx), .region(region), .csr_idx(csr_idx),
    .gpr_idx(gpr_idx), .win_off(win_off)
  );

  vcop_csr_file #(
    .DW(DW), .NUM_CSR(NUM_CSR), .CSR_AW(CSR_AW), .PAGE_W(PAGE_W)
  ) u_csr (
    .clk(clk), .rst(rst),
    .ctl_wr(wr_req && region == RG_CTL),
    .ctl_rd(rd_req && region == RG_CTL),
    .csr_wr(wr_req && region == RG_CSR),
    .csr_rd(rd_req && region == RG_CSR),
    .idx(csr_idx), .wdata(bus_wdata), .busy(run_busy),
    .rdata_q(csr_rd), .start_q(run_start),
    .mesh_base(cfg_mesh_base), .hlast(cfg_hlast), .vlast(cfg_vlast),
    .page(page)
  );

  vcop_gpr_file #(.DW(DW), .DEPTH(GPR_DEPTH), .AW(GPR_AW)) u_gpr (
    .clk(clk), .rst(rst),
    .bus_we(wr_req && region == RG_GPR),
    .bus_re(rd_req && region == RG_GPR),
    .bus_addr(gpr_idx), .bus_wdata(bus_wdata), .bus_rdata_q(gpr_rd),
    .seq_raddr(seq_gpr_raddr), .seq_rdata_q(seq_gpr_rdata),
    .seq_we(seq_gpr_we), .seq_waddr(seq_gpr_waddr), .seq_wdata(seq_gpr_wdata)
  );

  vcop_ucode_store #(.DW(DW), .DEPTH(UC_DEPTH), .AW(UC_AW)) u_uc (
    .clk(clk), .rst(rst),
    .a_we(wr_req && region == RG_UC),
    .a_re(rd_req && region == RG_UC),
    .a_addr({page, win_off}), .a_wdata(bus_wdata), .a_rdata(uc_rd),
    .b_addr(seq_uc_addr), .b_rdata(seq_uc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= RG_NONE;
      err_q    <= 1'b0;
    end else begin
      if (rd_req) region_q <= region;
      err_q <= bus_valid && region == RG_NONE;
    end
  end

  always_comb begin
    case (region_q)
      RG_CTL, RG_CSR: bus_rdata = csr_rd;
      RG_GPR:         bus_rdata = gpr_rd;
      RG_UC:          bus_rdata = uc_rd;
      default:        bus_rdata = '0;
    endcase
  end

  assign bus_err = err_q;
endmodule

// File: rtl/vcop_regwin_chk.sv
module vcop_regwin_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              run_start,
  input logic              run_busy,
  input logic [31:0]       cfg_mesh_base
);
  logic ctl_hit;
  assign ctl_hit = bus_addr[ADDR_W-1:2] == '0;

  AST_START_NEEDS_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
    run_start |-> $past(bus_valid && bus_write && ctl_hit && bus_wdata[0])); // R3

  AST_CTL_WRITE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && ctl_hit && bus_wdata[0]) |=> run_start); // R3

  AST_CTL_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && ctl_hit) |=> bus_rdata == {31'b0, $past(run_busy)}); // R4

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid)); // R9

  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_err && $past(!bus_write)) |-> bus_rdata == 32'd0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R11

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> $stable(cfg_mesh_base)); // R2
endmodule

bind vcop_regwin vcop_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .run_start(run_start), .run_busy(run_busy),
  .cfg_mesh_base(cfg_mesh_base)
);

// File: tb/sim_vcop_regwin.sv
module sim_vcop_regwin;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, run_start;
  logic        run_busy = 1'b0;
  logic [31:0] cfg_mesh_base, cfg_hlast, cfg_vlast;
  logic [6:0]  seq_gpr_raddr = '0, seq_gpr_waddr = '0;
  logic [31:0] seq_gpr_rdata, seq_gpr_wdata = '0, seq_uc_rdata;
  logic        seq_gpr_we = 1'b0;
  logic [10:0] seq_uc_addr = '0;

  int errors = 0, checks = 0;
  logic [31:0] csr_m [12];
  logic [31:0] gpr_m [128];
  logic [31:0] uc_m  [2048];

  always #5 clk = ~clk;

  vcop_regwin u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 12; i++) csr_m[i] = '0;
    for (int i = 0; i < 128; i++) gpr_m[i] = '0;
    for (int i = 0; i < 2048; i++) uc_m[i] = '0;
  endtask

  function automatic logic is_unmapped(input int w);
    return (w >= 12 && w < 256) || (w >= 384 && w < 512) || w >= 1024;
  endfunction

  function automatic logic [31:0] exp_read(input int w, input logic busy);
    if (w == 0) return {31'b0, busy};
    if (w < 12) return csr_m[w];
    if (w >= 256 && w < 384) return gpr_m[w - 256];
    if (w >= 512 && w < 1024) return uc_m[{csr_m[4][1:0], 9'(w - 512)}];
    return 32'd0;
  endfunction

  task automatic model_write(input int w, input logic [31:0] d);
    if (w >= 1 && w < 12) csr_m[w] = d;
    else if (w >= 256 && w < 384) gpr_m[w - 256] = d;
    else if (w >= 512 && w < 1024) uc_m[{csr_m[4][1:0], 9'(w - 512)}] = d;
  endtask

  // one access; results sampled on the falling edge after the capturing edge
  task automatic bus_op(input logic wr, input int w, input logic [1:0] lane,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic err, output logic st);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr;
    bus_addr = {12'(w), lane}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd = bus_rdata; err = bus_err; st = run_start;
    if (wr) model_write(w, d);
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    logic [31:0] r; logic e, s;
    bus_op(1'b1, w, 2'b00, d, r, e, s);
  endtask

  task automatic rd_chk(input string req, input int w);
    logic [31:0] r; logic e, s;
    logic [31:0] exp;
    exp = exp_read(w, run_busy);
    bus_op(1'b0, w, 2'b00, 32'h0, r, e, s);
    check(req, r, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r; logic e, s;
    void'($urandom(32'd20240611));
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 run_start", {31'b0, run_start}, 0);
    check("R10 bus_err", {31'b0, bus_err}, 0);
    check("R10 cfg_mesh_base", cfg_mesh_base, 0);
    rd_chk("R10 csr", 9);
    rd_chk("R10 gpr", 256 + 77);
    rd_chk("R10 ucode", 512 + 300);

    // R2 readback and configuration outputs
    for (int i = 1; i < 12; i++) wr(i, 32'hA500_0000 + i);
    wr(4, 0);
    for (int i = 1; i < 12; i++) rd_chk("R2 readback", i);
    check("R2 cfg_mesh_base", cfg_mesh_base, 32'hA500_0001);
    check("R2 cfg_hlast", cfg_hlast, 32'hA500_0002);
    check("R2 cfg_vlast", cfg_vlast, 32'hA500_0003);

    // R1 low address bits ignored
    bus_op(1'b1, 257, 2'b11, 32'h1234_5678, r, e, s);
    bus_op(1'b0, 257, 2'b10, 32'h0, r, e, s);
    check("R1 byte lane", r, 32'h1234_5678);

    // R3 start pulse and no storage of control
    bus_op(1'b1, 0, 2'b00, 32'hFFFF_FFFF, r, e, s);
    check("R3 start pulse", {31'b0, s}, 1);
    @(negedge clk);
    check("R3 pulse one cycle", {31'b0, run_start}, 0);
    bus_op(1'b1, 0, 2'b00, 32'hFFFF_FFFE, r, e, s);
    check("R3 bit0 clear no pulse", {31'b0, s}, 0);

    // R4 busy readback
    run_busy = 1'b1;
    rd_chk("R4 busy high", 0);
    run_busy = 1'b0;
    rd_chk("R4 busy low", 0);

    // R6 paging, wrap of page 7 to 3
    wr(4, 0); wr(512 + 5, 32'h0000_AAAA);
    wr(4, 3); wr(512 + 5, 32'h0000_BBBB);
    wr(4, 7); rd_chk("R6 page wraps", 512 + 5);
    wr(4, 0); rd_chk("R6 page zero", 512 + 5);

    // R7 sequencer microcode port
    @(negedge clk); seq_uc_addr = {2'b11, 9'd5};
    @(negedge clk); check("R7 seq ucode", seq_uc_rdata, 32'h0000_BBBB);
    seq_uc_addr = {2'b00, 9'd5};
    @(negedge clk); check("R7 seq ucode page0", seq_uc_rdata, 32'h0000_AAAA);

    // R8 sequencer write wins over a bus write to the same register
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {12'(256 + 5), 2'b00};
    bus_wdata = 32'h1111_1111;
    seq_gpr_we = 1'b1; seq_gpr_waddr = 7'd5; seq_gpr_wdata = 32'h2222_2222;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; seq_gpr_we = 1'b0;
    gpr_m[5] = 32'h2222_2222;
    rd_chk("R8 seq priority", 256 + 5);
    // R5 sequencer read port
    seq_gpr_raddr = 7'd5;
    @(negedge clk); check("R5 seq gpr read", seq_gpr_rdata, 32'h2222_2222);

    // R9 unmapped read, write, error flag
    bus_op(1'b1, 300 + 100, 2'b00, 32'hDEAD_BEEF, r, e, s);
    check("R9 write err", {31'b0, e}, 1);
    @(negedge clk); check("R9 err one cycle", {31'b0, bus_err}, 0);
    bus_op(1'b0, 400, 2'b00, 32'h0, r, e, s);
    check("R9 read zero", r, 0);
    check("R9 read err", {31'b0, e}, 1);
    rd_chk("R9 write ignored gpr", 256 + 16);
    rd_chk("R9 write ignored ucode", 512 + 16);

    // R11 hold after idle cycles
    rd_chk("R11 setup", 2);
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, csr_m[2]);

    // random mix over all regions
    for (int n = 0; n < 600; n++) begin
      int reg_sel, w;
      logic dowr;
      logic [31:0] d, exp;
      reg_sel = $urandom_range(0, 4);
      dowr = $urandom_range(0, 1) == 1;
      d = $urandom();
      run_busy = $urandom_range(0, 1) == 1;
      case (reg_sel)
        0: begin w = 0; dowr = 1'b0; end
        1: w = $urandom_range(1, 11);
        2: w = 256 + $urandom_range(0, 127);
        3: w = 512 + $urandom_range(0, 511);
        default: case ($urandom_range(0, 2))
          0: w = $urandom_range(12, 255);
          1: w = $urandom_range(384, 511);
          default: w = $urandom_range(1024, 4095);
        endcase
      endcase
      exp = exp_read(w, run_busy);
      bus_op(dowr, w, 2'($urandom_range(0, 3)), d, r, e, s);
      check("R9 random err flag", {31'b0, e}, {31'b0, is_unmapped(w)});
      if (!dowr) check(w >= 512 && w < 1024 ? "R6 random read" : "R5 random read", r, exp);
    end
    run_busy = 1'b0;

    // R10 reset after traffic
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    clear_model();
    rd_chk("R10 gpr after reset", 256 + 5);
    rd_chk("R10 csr after reset", 1);
    wr(4, 3);
    rd_chk("R10 ucode after reset", 512 + 5);
    seq_uc_addr = {2'b11, 9'd5};
    @(negedge clk); check("R10 seq ucode after reset", seq_uc_rdata, 0);
    check("R10 cfg after reset", cfg_hlast, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule